// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation buffer with 64 slots. It maps virtual pages to physical pages. Each slot holds a tag and a payload. The tag is an 8-bit address space identifier, virtual address bits 31..10 and a valid flag. The payload is physical page bits 28..10 and a 12-bit attribute word. The attribute word carries a page-size code, a global-sharing flag, a cacheable flag, a two-bit access-rights field, a modified flag, a write-through flag, a three-bit bus-space field and a bus-timing flag.

Two lookup ports read the same slots at the same time. The data port takes a full 32-bit virtual address and returns the translated physical address and the attribute word. The refill port takes a virtual page number and returns the whole matching slot, so that a smaller instruction-side buffer can copy it after a miss. Both ports compare against the current address space identifier. Both register their result one cycle after the request.

A write port loads one slot at a chosen index. A purge input clears every valid flag in a single cycle. Software uses the purge when the current identifier changes, so that stale private translations cannot match.

Top module: `utlb_top`

## Requirements
- R1: The buffer has 64 slots and a translation may sit in any of them, index 0 through 63. After reset no slot is valid, so every lookup misses.
- R2: A write stores the tag and payload at `wr_index` on the clock edge. A lookup issued in the same cycle as a write sees the old contents. A lookup issued from the next cycle on sees the new contents, and a rewritten slot no longer matches its old page.
- R3: A slot whose sharing flag (attribute bit 9) is 0 matches only when its stored identifier equals `cur_asid`. A slot whose sharing flag is 1 matches under any identifier.
- R4: The size code in attribute bits 11..10 sets the page size and so which virtual bits are compared. Code 00 is 1 KB and compares virtual bits 31..10. Code 01 is 4 KB and ignores bits 11..10. Code 10 is 64 KB and ignores bits 15..10. Code 11 is 1 MB and ignores bits 19..10.
- R5: On a data-port hit, `dres_paddr` takes the stored physical page bits above the page boundary. Below the boundary, including bits 9..0, it takes the request's virtual address bits.
- R6: When two or more valid slots match one lookup, that port reports multiple-hit and reports neither hit nor miss. In every valid result exactly one of hit, miss and multiple-hit is 1.
- R7: A request sampled on one clock edge produces its result flags, with the port's valid output high, right after that same edge. A cycle with no request leaves all of that port's result flags at 0 after the next edge.
- R8: Purge clears every valid flag in one cycle, so a lookup issued on the cycle after the purge misses. Purge takes priority over a write in the same cycle, and that write is dropped.
- R9: On a refill-port hit, the port returns the matching slot's identifier, virtual page number, physical page number and attribute word unchanged.
- R10: The attribute outputs use this layout: [11:10] size, [9] sharing, [8] cacheable, [7:6] access rights, [5] modified, [4] write-through, [3:1] bus space, [0] timing. On a miss or a multiple-hit, both ports drive every page and attribute output to 0.
- R11: A slot written with its valid flag at 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | 8 | Current address space identifier |
| purge | input | 1 | Invalidate all slots |
| wr_en | input | 1 | Write strobe |
| wr_index | input | 6 | Slot to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_asid | input | 8 | Identifier to store |
| wr_vpn | input | 22 | Virtual page number (VA 31..10) to store |
| wr_ppn | input | 19 | Physical page number (PA 28..10) to store |
| wr_attr | input | 12 | Attribute word to store |
| dreq_valid | input | 1 | Data lookup request |
| dreq_vaddr | input | 32 | Data lookup virtual address |
| dres_valid | output | 1 | Data result present |
| dres_hit | output | 1 | Data lookup: single match |
| dres_miss | output | 1 | Data lookup: no match |
| dres_multi | output | 1 | Data lookup: several matches |
| dres_paddr | output | 29 | Translated physical address |
| dres_attr | output | 12 | Attribute word of the hit |
| ireq_valid | input | 1 | Refill lookup request |
| ireq_vpn | input | 22 | Refill lookup virtual page number |
| ires_valid | output | 1 | Refill result present |
| ires_hit | output | 1 | Refill lookup: single match |
| ires_miss | output | 1 | Refill lookup: no match |
| ires_multi | output | 1 | Refill lookup: several matches |
| ires_asid | output | 8 | Identifier of the hit slot |
| ires_vpn | output | 22 | Virtual page number of the hit slot |
| ires_ppn | output | 19 | Physical page number of the hit slot |
| ires_attr | output | 12 | Attribute word of the hit slot |

## Verification
Every lookup result comes out of one register stage. A request that is set up half a cycle before an edge has its flags, address and attributes present right after that edge, so the bench samples one time unit past it. A write or purge changes the slot state on its own edge. Only a request issued in the following cycle shows that change, and the check for it is sampled one edge later. The same-cycle case is checked on both edges, to tell the old contents from the new.

// File: rtl/utlb_pkg.sv
// Package: shared widths, slot type and the page-size compare mask.
// Assumes a 32-bit virtual and a 29-bit physical address with 1 KB minimum pages.
package utlb_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 29;
    localparam int OFF_W   = 10;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int ASID_W  = 8;
    localparam int ATTR_W  = 12;
    localparam int SZ_LO   = 10;
    localparam int SHR_BIT = 9;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ATTR_W-1:0] attr;
    } slot_t;

    // Returns 1 for each page-number bit that takes part in the compare.
    function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
        case (sz)
            2'b00:   vpn_cmp_mask = '1;
            2'b01:   vpn_cmp_mask = {{(VPN_W-2){1'b1}}, 2'b0};
            2'b10:   vpn_cmp_mask = {{(VPN_W-6){1'b1}}, 6'b0};
            default: vpn_cmp_mask = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
    endfunction
endpackage

// File: rtl/utlb_store.sv
// Slot array: holds the tags and payloads and the valid flags.
// Assumes a purge outranks a write in the same cycle. Payload storage is not reset.
module utlb_store
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                purge,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  slot_t               wr_slot,
    output slot_t [ENTRIES-1:0] slots,
    output logic  [ENTRIES-1:0] valids
);
    // Valid flags: cleared by reset or purge, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valids <= '0;
        else if (purge)
            valids <= '0;
        else if (wr_en)
            valids[wr_idx] <= wr_valid;
    end

    // Payload and tag storage: loaded by a write that no purge overrides.
    always_ff @(posedge clk) begin
        if (wr_en && !purge)
            slots[wr_idx] <= wr_slot;
    end
endmodule

// File: rtl/utlb_lookup.sv
// Lookup: compares all slots in parallel and picks the matching slot.
// Assumes the caller tells hit from multiple-hit. sel is only meaningful on a single hit.
module utlb_lookup
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  slot_t [ENTRIES-1:0] slots,
    input  logic  [ENTRIES-1:0] valids,
    input  logic  [VPN_W-1:0]   vpn,
    input  logic  [ASID_W-1:0]  asid,
    output logic                hit,
    output logic                multi,
    output slot_t               sel
);
    logic [ENTRIES-1:0] match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VPN_W-1:0] keep;
        logic             id_ok;
        // Per-slot compare: page bits under the size mask, identifier unless shared.
        always_comb begin
            keep     = vpn_cmp_mask(slots[i].attr[SZ_LO +: 2]);
            id_ok    = slots[i].attr[SHR_BIT] || (slots[i].asid == asid);
            match[i] = valids[i] && id_ok && (((slots[i].vpn ^ vpn) & keep) == '0);
        end
    end

    // Result flags from the match vector.
    always_comb begin
        hit   = $onehot(match);
        multi = (match != '0) && !$onehot(match);
    end

    // One-hot OR mux of the matching slot.
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i])
                sel = sel | slots[i];
    end
endmodule

// File: rtl/utlb_top.sv
// Top: slot array shared by a data-translation port and a refill port.
// Both ports register their result one cycle after the request.
module utlb_top
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cur_asid,
    input  logic              purge,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_valid,
    input  logic [7:0]        wr_asid,
    input  logic [21:0]       wr_vpn,
    input  logic [18:0]       wr_ppn,
    input  logic [11:0]       wr_attr,
    input  logic              dreq_valid,
    input  logic [31:0]       dreq_vaddr,
    output logic              dres_valid,
    output logic              dres_hit,
    output logic              dres_miss,
    output logic              dres_multi,
    output logic [28:0]       dres_paddr,
    output logic [11:0]       dres_attr,
    input  logic              ireq_valid,
    input  logic [21:0]       ireq_vpn,
    output logic              ires_valid,
    output logic              ires_hit,
    output logic              ires_miss,
    output logic              ires_multi,
    output logic [7:0]        ires_asid,
    output logic [21:0]       ires_vpn,
    output logic [18:0]       ires_ppn,
    output logic [11:0]       ires_attr
);
    slot_t [ENTRIES-1:0] slots;
    logic  [ENTRIES-1:0] valids;
    slot_t               wr_slot;
    slot_t               d_sel, i_sel;
    logic                d_hit, d_multi, i_hit, i_multi;
    logic  [PPN_W-1:0]   d_keep, d_ppn;

    // Write-port packing into the slot layout.
    always_comb wr_slot = '{asid: wr_asid, vpn: wr_vpn, ppn: wr_ppn, attr: wr_attr};

    utlb_store #(.ENTRIES(ENTRIES)) i_store (
        .clk(clk), .rst_n(rst_n), .purge(purge), .wr_en(wr_en),
        .wr_idx(wr_index), .wr_valid(wr_valid), .wr_slot(wr_slot),
        .slots(slots), .valids(valids)
    );

    utlb_lookup #(.ENTRIES(ENTRIES)) i_dlook (
        .slots(slots), .valids(valids), .vpn(dreq_vaddr[VA_W-1:OFF_W]),
        .asid(cur_asid), .hit(d_hit), .multi(d_multi), .sel(d_sel)
    );

    utlb_lookup #(.ENTRIES(ENTRIES)) i_ilook (
        .slots(slots), .valids(valids), .vpn(ireq_vpn),
        .asid(cur_asid), .hit(i_hit), .multi(i_multi), .sel(i_sel)
    );

    // Physical page merge: stored bits above the page boundary, virtual bits below.
    always_comb begin
        d_keep = PPN_W'(vpn_cmp_mask(d_sel.attr[SZ_LO +: 2]));
        d_ppn  = (d_sel.ppn & d_keep) | (dreq_vaddr[PA_W-1:OFF_W] & ~d_keep);
    end

    // Data-port result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dres_valid <= 1'b0; dres_hit <= 1'b0; dres_miss <= 1'b0; dres_multi <= 1'b0;
            dres_paddr <= '0;   dres_attr <= '0;
        end else begin
            dres_valid <= dreq_valid;
            dres_hit   <= dreq_valid && d_hit;
            dres_miss  <= dreq_valid && !d_hit && !d_multi;
            dres_multi <= dreq_valid && d_multi;
            dres_paddr <= (dreq_valid && d_hit) ? {d_ppn, dreq_vaddr[OFF_W-1:0]} : '0;
            dres_attr  <= (dreq_valid && d_hit) ? d_sel.attr : '0;
        end
    end

    // Refill-port result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ires_valid <= 1'b0; ires_hit <= 1'b0; ires_miss <= 1'b0; ires_multi <= 1'b0;
            ires_asid  <= '0;   ires_vpn <= '0;   ires_ppn <= '0;    ires_attr <= '0;
        end else begin
            ires_valid <= ireq_valid;
            ires_hit   <= ireq_valid && i_hit;
            ires_miss  <= ireq_valid && !i_hit && !i_multi;
            ires_multi <= ireq_valid && i_multi;
            ires_asid  <= (ireq_valid && i_hit) ? i_sel.asid : '0;
            ires_vpn   <= (ireq_valid && i_hit) ? i_sel.vpn  : '0;
            ires_ppn   <= (ireq_valid && i_hit) ? i_sel.ppn  : '0;
            ires_attr  <= (ireq_valid && i_hit) ? i_sel.attr : '0;
        end
    end
endmodule

// File: rtl/utlb_checker.sv
// Checker: temporal properties of the two result ports, bound to utlb_top.
// Assumes the synchronous active-low reset of the top module.
module utlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        purge,
    input logic        dreq_valid,
    input logic [9:0]  dreq_off,
    input logic        dres_valid,
    input logic        dres_hit,
    input logic        dres_miss,
    input logic        dres_multi,
    input logic [28:0] dres_paddr,
    input logic [11:0] dres_attr,
    input logic        ireq_valid,
    input logic        ires_valid,
    input logic        ires_hit,
    input logic        ires_miss,
    input logic        ires_multi,
    input logic [18:0] ires_ppn,
    input logic [11:0] ires_attr
);
    logic [1:0] age;

    // Edges since reset, saturating, to bound $past look-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    p_dreq_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_valid |=> dres_valid);
    p_didle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dreq_valid |=> !(dres_valid || dres_hit || dres_miss || dres_multi));
    p_ireq_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ireq_valid |=> ires_valid);
    p_dflags_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dres_valid |-> $countones({dres_hit, dres_miss, dres_multi}) == 1);
    p_iflags_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ires_valid |-> $countones({ires_hit, ires_miss, ires_multi}) == 1);
    p_dzero_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dres_valid && !dres_hit) |-> (dres_paddr == '0 && dres_attr == '0));
    p_izero_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ires_valid && !ires_hit) |-> (ires_ppn == '0 && ires_attr == '0));
    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && dres_hit) |-> dres_paddr[9:0] == $past(dreq_off));
    p_purge_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(purge, 2) && $past(dreq_valid)) |-> dres_miss);
endmodule

bind utlb_top utlb_checker i_chk (
    .clk(clk), .rst_n(rst_n), .purge(purge), .dreq_valid(dreq_valid),
    .dreq_off(dreq_vaddr[9:0]), .dres_valid(dres_valid), .dres_hit(dres_hit),
    .dres_miss(dres_miss), .dres_multi(dres_multi), .dres_paddr(dres_paddr),
    .dres_attr(dres_attr), .ireq_valid(ireq_valid), .ires_valid(ires_valid),
    .ires_hit(ires_hit), .ires_miss(ires_miss), .ires_multi(ires_multi),
    .ires_ppn(ires_ppn), .ires_attr(ires_attr)
);

// File: tb/test_utlb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module test_utlb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic        purge = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_index = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [21:0] wr_vpn = '0;
    logic [18:0] wr_ppn = '0;
    logic [11:0] wr_attr = '0;
    logic        dreq_valid = 1'b0;
    logic [31:0] dreq_vaddr = '0;
    logic        dres_valid, dres_hit, dres_miss, dres_multi;
    logic [28:0] dres_paddr;
    logic [11:0] dres_attr;
    logic        ireq_valid = 1'b0;
    logic [21:0] ireq_vpn = '0;
    logic        ires_valid, ires_hit, ires_miss, ires_multi;
    logic [7:0]  ires_asid;
    logic [21:0] ires_vpn;
    logic [18:0] ires_ppn;
    logic [11:0] ires_attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    utlb_top i_utlb_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [11:0] mk_attr(input logic [1:0] sz, input logic sh, input logic [8:0] rest);
        return {sz, sh, rest};
    endfunction

    function automatic logic [28:0] exp_pa(input logic [18:0] ppn, input logic [1:0] sz, input logic [31:0] va);
        int ob;
        logic [28:0] lowm;
        ob   = (sz == 2'd0) ? 10 : (sz == 2'd1) ? 12 : (sz == 2'd2) ? 16 : 20;
        lowm = (29'd1 << ob) - 29'd1;
        return ({ppn, 10'b0} & ~lowm) | (va[28:0] & lowm);
    endfunction

    task automatic wr(input logic [5:0] idx, input logic [7:0] a, input logic [21:0] v,
                      input logic vl, input logic [18:0] p, input logic [11:0] at);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_asid = a; wr_vpn = v; wr_valid = vl; wr_ppn = p; wr_attr = at;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_purge();
        @(negedge clk); purge = 1'b1;
        @(negedge clk); purge = 1'b0;
    endtask

    task automatic dlook(input logic [31:0] va);
        @(negedge clk); dreq_valid = 1'b1; dreq_vaddr = va;
        @(posedge clk); #1;
    endtask

    task automatic dend();
        @(negedge clk); dreq_valid = 1'b0;
    endtask

    task automatic ilook(input logic [21:0] v);
        @(negedge clk); ireq_valid = 1'b1; ireq_vpn = v;
        @(posedge clk); #1;
    endtask

    task automatic iend();
        @(negedge clk); ireq_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7", "dres_valid after reset", dres_valid, 0);
        chk("R7", "ires_valid after reset", ires_valid, 0);
        dlook(32'h1234_5678);
        chk("R1", "empty data miss", {dres_valid, dres_hit, dres_miss, dres_multi}, 4'b1010);
        dend();
        ilook(22'h0);
        chk("R1", "empty refill miss", {ires_valid, ires_hit, ires_miss, ires_multi}, 4'b1010);
        iend();
        @(posedge clk); #1;
        chk("R7", "idle data flags", {dres_valid, dres_hit, dres_miss, dres_multi}, 4'b0);
    endtask

    task automatic t_basic();
        logic [31:0] va;
        do_purge();
        cur_asid = 8'd3;
        wr(6'd5, 8'd3, 22'h12345, 1'b1, 19'h51234, mk_attr(2'b00, 1'b0, 9'h1A5));
        wr(6'd63, 8'd3, 22'h3ABCD, 1'b1, 19'h00F0F, mk_attr(2'b00, 1'b0, 9'h0FF));
        va = {22'h12345, 10'h2B7};
        dlook(va);
        chk("R7", "hit flags", {dres_valid, dres_hit, dres_miss, dres_multi}, 4'b1100);
        chk("R5", "paddr slot 5", dres_paddr, exp_pa(19'h51234, 2'b00, va));
        chk("R10", "attr slot 5", dres_attr, mk_attr(2'b00, 1'b0, 9'h1A5));
        dend();
        va = {22'h3ABCD, 10'h001};
        dlook(va);
        chk("R1", "slot 63 hit", dres_hit, 1);
        chk("R5", "paddr slot 63", dres_paddr, exp_pa(19'h00F0F, 2'b00, va));
        dend();
        dlook({22'h12346, 10'h0});
        chk("R10", "miss zero outputs", {dres_miss, dres_paddr, dres_attr}, {1'b1, 29'b0, 12'b0});
        dend();
    endtask

    task automatic t_asid();
        do_purge();
        wr(6'd6, 8'd9, 22'h00777, 1'b1, 19'h00111, mk_attr(2'b00, 1'b0, 9'h0));
        wr(6'd7, 8'd9, 22'h00888, 1'b1, 19'h00222, mk_attr(2'b00, 1'b1, 9'h0));
        cur_asid = 8'd4;
        dlook({22'h00777, 10'h0});
        chk("R3", "private slot other id", dres_miss, 1);
        dend();
        dlook({22'h00888, 10'h0});
        chk("R3", "shared slot other id", dres_hit, 1);
        dend();
        cur_asid = 8'd9;
        dlook({22'h00777, 10'h0});
        chk("R3", "private slot own id", dres_hit, 1);
        dend();
    endtask

    task automatic t_size();
        logic [31:0] va;
        do_purge();
        cur_asid = 8'd3;
        wr(6'd10, 8'd3, 22'h2A800, 1'b1, 19'h7FC00, mk_attr(2'b11, 1'b0, 9'h0));
        wr(6'd11, 8'd3, 22'h01230, 1'b1, 19'h04440, mk_attr(2'b01, 1'b0, 9'h0));
        wr(6'd12, 8'd3, 22'h00C40, 1'b1, 19'h12340, mk_attr(2'b10, 1'b0, 9'h0));
        wr(6'd13, 8'd3, 22'h05550, 1'b1, 19'h00AAA, mk_attr(2'b00, 1'b0, 9'h0));
        va = {22'h2A955, 10'h3C1};
        dlook(va);
        chk("R4", "1MB low bits ignored", dres_hit, 1);
        chk("R5", "1MB paddr", dres_paddr, exp_pa(19'h7FC00, 2'b11, va));
        dend();
        dlook({22'h2AC00, 10'h0});
        chk("R4", "1MB bit 20 compared", dres_miss, 1);
        dend();
        va = {22'h01233, 10'h055};
        dlook(va);
        chk("R4", "4KB low bits ignored", dres_hit, 1);
        chk("R5", "4KB paddr", dres_paddr, exp_pa(19'h04440, 2'b01, va));
        dend();
        dlook({22'h01234, 10'h0});
        chk("R4", "4KB bit 12 compared", dres_miss, 1);
        dend();
        va = {22'h00C7F, 10'h3FF};
        dlook(va);
        chk("R4", "64KB low bits ignored", dres_hit, 1);
        chk("R5", "64KB paddr", dres_paddr, exp_pa(19'h12340, 2'b10, va));
        dend();
        dlook({22'h00C80, 10'h0});
        chk("R4", "64KB bit 16 compared", dres_miss, 1);
        dend();
        dlook({22'h05551, 10'h0});
        chk("R4", "1KB bit 10 compared", dres_miss, 1);
        dend();
    endtask

    task automatic t_multi();
        do_purge();
        cur_asid = 8'd3;
        wr(6'd20, 8'd3, 22'h0ABCD, 1'b1, 19'h00100, mk_attr(2'b00, 1'b0, 9'h3));
        wr(6'd40, 8'd1, 22'h0ABCD, 1'b1, 19'h00200, mk_attr(2'b00, 1'b1, 9'h5));
        dlook({22'h0ABCD, 10'h0});
        chk("R6", "data multi flags", {dres_valid, dres_hit, dres_miss, dres_multi}, 4'b1001);
        chk("R10", "multi zero outputs", {dres_paddr, dres_attr}, 41'b0);
        dend();
        ilook(22'h0ABCD);
        chk("R6", "refill multi flags", {ires_hit, ires_miss, ires_multi}, 3'b001);
        iend();
    endtask

    task automatic t_invalid();
        do_purge();
        cur_asid = 8'd3;
        wr(6'd30, 8'd3, 22'h11111, 1'b0, 19'h00333, mk_attr(2'b00, 1'b1, 9'h0));
        dlook({22'h11111, 10'h0});
        chk("R11", "invalid slot miss", dres_miss, 1);
        dend();
    endtask

    task automatic t_same_cycle();
        do_purge();
        cur_asid = 8'd3;
        wr(6'd5, 8'd3, 22'h22222, 1'b1, 19'h00444, mk_attr(2'b00, 1'b0, 9'h0));
        @(negedge clk);
        wr_en = 1'b1; wr_index = 6'd21; wr_asid = 8'd3; wr_vpn = 22'h33333; wr_valid = 1'b1;
        wr_ppn = 19'h00555; wr_attr = mk_attr(2'b00, 1'b0, 9'h0);
        dreq_valid = 1'b1; dreq_vaddr = {22'h33333, 10'h0};
        @(posedge clk); #1;
        chk("R2", "same-cycle write unseen", dres_miss, 1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R2", "next-cycle write seen", dres_hit, 1);
        dend();
        wr(6'd5, 8'd3, 22'h24444, 1'b1, 19'h00444, mk_attr(2'b00, 1'b0, 9'h0));
        dlook({22'h22222, 10'h0});
        chk("R2", "overwritten page gone", dres_miss, 1);
        dend();
    endtask

    task automatic t_refill();
        do_purge();
        cur_asid = 8'd3;
        wr(6'd50, 8'd3, 22'h3F00F, 1'b1, 19'h6789A, mk_attr(2'b01, 1'b0, 9'h16B));
        ilook(22'h3F00F);
        chk("R9", "refill hit", {ires_valid, ires_hit, ires_miss, ires_multi}, 4'b1100);
        chk("R9", "refill slot", {ires_asid, ires_vpn, ires_ppn, ires_attr},
            {8'd3, 22'h3F00F, 19'h6789A, mk_attr(2'b01, 1'b0, 9'h16B)});
        iend();
        ilook(22'h3F010);
        chk("R10", "refill miss zero", {ires_miss, ires_ppn, ires_attr}, {1'b1, 19'b0, 12'b0});
        iend();
    endtask

    task automatic t_purge();
        cur_asid = 8'd3;
        wr(6'd2, 8'd3, 22'h0F0F0, 1'b1, 19'h00777, mk_attr(2'b00, 1'b1, 9'h0));
        dlook({22'h0F0F0, 10'h0});
        chk("R8", "hit before purge", dres_hit, 1);
        dend();
        do_purge();
        dlook({22'h0F0F0, 10'h0});
        chk("R8", "miss after purge", dres_miss, 1);
        dend();
        @(negedge clk);
        purge = 1'b1; wr_en = 1'b1; wr_index = 6'd3; wr_asid = 8'd3; wr_vpn = 22'h0F0F1;
        wr_valid = 1'b1; wr_ppn = 19'h00888; wr_attr = mk_attr(2'b00, 1'b1, 9'h0);
        @(negedge clk); purge = 1'b0; wr_en = 1'b0;
        dlook({22'h0F0F1, 10'h0});
        chk("R8", "write under purge dropped", dres_miss, 1);
        dend();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_asid();
        t_size();
        t_multi();
        t_invalid();
        t_same_cycle();
        t_refill();
        t_purge();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run not finished actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule